// File: doc/BRIEF.md
# Sampled Cache Footprint Monitor

This block estimates how much of a 4-way, 512-set data cache a program is really using. It does not keep state for every set. It watches a fixed subset of 32 sets, spaced sixteen apart starting at set 0. For each watched set it keeps one touched flag per way. A cache hit that lands in a watched set marks the flag of the way that hit.

The block sums all 128 flags into a single footprint count. A resize controller reads this count when it has to decide whether to grow or shrink the cache. Once that decision has been taken, the controller issues a synchronous clear so that the next observation phase starts from an empty record.

The access event bus carries a valid strobe, a hit flag, the 9-bit set index and the 2-bit way of the hit. The block only observes this bus and never drives the cache.

Top module: `sampled_footprint_monitor`

## Requirements
- R1: After reset every touched flag is zero and `footprint` reads 0.
- R2: A valid hit whose set index has its low 4 bits equal to zero marks flag number `acc_set[8:4]*4 + acc_way`, which raises `footprint` by one if that flag was clear.
- R3: A hit to a set whose low 4 index bits are not all zero leaves every flag and `footprint` unchanged.
- R4: An event with `acc_hit` low (a miss), or with `acc_valid` low, leaves every flag and `footprint` unchanged.
- R5: Repeated hits to a flag that is already marked do not raise `footprint` again.
- R6: `footprint` equals the number of marked flags among all 128. It ranges from 0 to 128 and reaches 128 when every way of every sampled set has been hit.
- R7: The flags update on the clock edge that samples the event, and `footprint` shows the new count on the following edge. That is one cycle of latency after the flag update.
- R8: A cycle with `clear_req` high zeroes all flags on that edge, and `footprint` reads 0 one edge later.
- R9: When `clear_req` and a valid sampled hit arrive in the same cycle, the clear wins and the hit is not recorded.
- R10: Different ways of one sampled set, and the same way of different sampled sets, are counted as separate flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_hit | input | 1 | The access hit in the cache |
| acc_set | input | 9 | Set index of the access |
| acc_way | input | 2 | Way that hit |
| clear_req | input | 1 | Synchronous clear of all touched flags |
| footprint | output | 8 | Number of marked flags, from 0 to 128 |

## Verification
Directed patterns are used first, and each one separates a distinct case:
- hits in the first and last sampled sets, which check the entry decode at both ends;
- hits one index above a sampled set, which must be dropped;
- misses, and hits with the valid strobe low;
- repeated hits to one way, which must not be counted twice;
- all four ways of a single set, which must each be counted.

A sweep over every sampled set and every way drives the count to its ceiling of 128. A clear issued together with a hit shows that the clear has priority. A long stretch of random traffic then mixes sampled and unsampled sets with occasional clears. Throughout that stretch the count is compared every cycle against a behavioural model, which also checks the one-cycle lag between a flag update and the count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  parameter int FP_SET_W      = 9;
  parameter int FP_WAY_W      = 2;
  parameter int FP_STRIDE_LOG = 4;

  typedef enum logic [1:0] {
    FP_HOLD = 2'd0,
    FP_MARK = 2'd1,
    FP_WIPE = 2'd2
  } fp_act_e;
endpackage

// File: rtl/fpm_sample_decode.sv
module fpm_sample_decode
  import fpm_pkg::*;
#(
  parameter int SET_W      = FP_SET_W,
  parameter int STRIDE_LOG = FP_STRIDE_LOG,
  localparam int ENTRY_W   = SET_W - STRIDE_LOG
) (
  input  logic               valid,
  input  logic               hit,
  input  logic [SET_W-1:0]   set_idx,
  input  logic               clear,
  output fp_act_e            act,
  output logic [ENTRY_W-1:0] entry
);
  function automatic logic is_sampled(input logic [SET_W-1:0] s);
    return s[STRIDE_LOG-1:0] == '0;
  endfunction

  function automatic logic [ENTRY_W-1:0] entry_of(input logic [SET_W-1:0] s);
    return s[SET_W-1:STRIDE_LOG];
  endfunction

  logic sampled_hit;

  assign sampled_hit = valid && hit && is_sampled(set_idx);
  assign entry       = entry_of(set_idx);

  always_comb begin
    if (clear)            act = FP_WIPE;
    else if (sampled_hit) act = FP_MARK;
    else                  act = FP_HOLD;
  end
endmodule

// File: rtl/fpm_touch_store.sv
module fpm_touch_store
  import fpm_pkg::*;
#(
  parameter int ENTRY_W = FP_SET_W - FP_STRIDE_LOG,
  parameter int WAY_W   = FP_WAY_W,
  localparam int ENTRIES = 1 << ENTRY_W,
  localparam int WAYS    = 1 << WAY_W,
  localparam int TOTAL   = ENTRIES * WAYS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fp_act_e            act,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [WAY_W-1:0]   way,
  output logic [TOTAL-1:0]   bits
);
  logic [ENTRY_W+WAY_W-1:0] mark_idx;
  assign mark_idx = {entry, way};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic [WAYS-1:0] row;
    logic            row_sel;

    assign row_sel = (entry == ENTRY_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row <= '0;
      end else if (act == FP_WIPE) begin
        row <= '0;
      end else if (act == FP_MARK && row_sel) begin
        row[way] <= 1'b1;
      end
    end

    assign bits[g*WAYS +: WAYS] = row;
  end

  // R8: a wipe empties the whole store on the next edge
  p_wipe_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act == FP_WIPE |=> bits == '0);

  // R2: a mark leaves the addressed flag set
  p_mark_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act == FP_MARK |=> bits[$past(mark_idx)]);

  // R3, R4: no action leaves the store untouched
  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act == FP_HOLD |=> $stable(bits));

  // R5: a mark never clears any flag
  p_mark_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act == FP_MARK |=> (bits & $past(bits)) == $past(bits));
endmodule

// File: rtl/fpm_popcount.sv
module fpm_popcount #(
  parameter int TOTAL  = 128,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOTAL-1:0] bits,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] ones_in(input logic [TOTAL-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TOTAL; i++) begin
      acc = acc + CNT_W'(v[i]);
    end
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= ones_in(bits);
  end

  // R6: the count never exceeds the number of flags
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(TOTAL));

  // R7: a steady flag set gives a steady count one cycle later
  p_count_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bits) |=> $stable(count));
endmodule

// File: rtl/sampled_footprint_monitor.sv
module sampled_footprint_monitor
  import fpm_pkg::*;
#(
  parameter int SET_W      = FP_SET_W,
  parameter int WAY_W      = FP_WAY_W,
  parameter int STRIDE_LOG = FP_STRIDE_LOG,
  localparam int ENTRY_W   = SET_W - STRIDE_LOG,
  localparam int TOTAL     = (1 << ENTRY_W) * (1 << WAY_W),
  localparam int CNT_W     = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             clear_req,
  output logic [CNT_W-1:0] footprint
);
  fp_act_e            store_act;
  logic [ENTRY_W-1:0] store_entry;
  logic [TOTAL-1:0]   touched_bits;

  fpm_sample_decode #(
    .SET_W      (SET_W),
    .STRIDE_LOG (STRIDE_LOG)
  ) u_decode (
    .valid   (acc_valid),
    .hit     (acc_hit),
    .set_idx (acc_set),
    .clear   (clear_req),
    .act     (store_act),
    .entry   (store_entry)
  );

  fpm_touch_store #(
    .ENTRY_W (ENTRY_W),
    .WAY_W   (WAY_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (store_act),
    .entry (store_entry),
    .way   (acc_way),
    .bits  (touched_bits)
  );

  fpm_popcount #(
    .TOTAL (TOTAL)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .bits  (touched_bits),
    .count (footprint)
  );

  // R3: hits outside the sampled sets leave the flags alone
  p_unsampled_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit && acc_set[STRIDE_LOG-1:0] != '0 && !clear_req)
      |=> $stable(touched_bits));

  // R4: misses and idle cycles leave the flags alone
  p_miss_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!acc_valid || !acc_hit) && !clear_req) |=> $stable(touched_bits));

  // R9: a clear wins over a simultaneous hit
  p_clear_beats_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && acc_valid && acc_hit) |=> touched_bits == '0);

  // R1: nothing is counted while the store is empty one cycle earlier
  p_empty_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (touched_bits == '0) |=> footprint == '0);
endmodule

// File: tb/sampled_footprint_monitor_tb.sv
module sampled_footprint_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_hit = 1'b0;
  logic [8:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic       clear_req = 1'b0;
  logic [7:0] footprint;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit mdl [128];
  int exp_fp = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sampled_footprint_monitor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_hit   (acc_hit),
    .acc_set   (acc_set),
    .acc_way   (acc_way),
    .clear_req (clear_req),
    .footprint (footprint)
  );

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < 128; i++) n += int'(mdl[i]);
    return n;
  endfunction

  // behavioural reference: count lags the flag record by one edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mdl[i] = 1'b0;
      exp_fp = 0;
    end else begin
      exp_fp = model_count();
      if (clear_req) begin
        for (int i = 0; i < 128; i++) mdl[i] = 1'b0;
      end else if (acc_valid && acc_hit && (acc_set % 16) == 0) begin
        mdl[(acc_set / 16) * 4 + acc_way] = 1'b1;
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R7 timing, R6 value)
  always @(negedge clk) begin
    if (rst_n && !done) chk(int'(footprint), exp_fp, "R7 per-cycle");
  end

  task automatic drive(input bit v, input bit h, input int s, input int w, input bit c);
    acc_valid = v;
    acc_hit   = h;
    acc_set   = 9'(s);
    acc_way   = 2'(w);
    clear_req = c;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_hit   = 1'b0;
    clear_req = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(footprint), 0, "R1 in reset");
    rst_n = 1'b1;
    settle();
    chk(int'(footprint), 0, "R1 after reset");

    drive(1, 1, 0, 0, 0); settle();
    chk(int'(footprint), 1, "R2 first set");
    drive(1, 1, 496, 3, 0); settle();
    chk(int'(footprint), 2, "R2 last set");

    drive(1, 1, 17, 1, 0); drive(1, 1, 8, 2, 0); settle();
    chk(int'(footprint), 2, "R3 unsampled");

    drive(1, 0, 32, 0, 0); drive(0, 1, 32, 1, 0); settle();
    chk(int'(footprint), 2, "R4 miss or idle");

    drive(1, 1, 0, 0, 0); drive(1, 1, 0, 0, 0); settle();
    chk(int'(footprint), 2, "R5 repeat");

    drive(1, 1, 0, 1, 0); drive(1, 1, 0, 2, 0); drive(1, 1, 0, 3, 0);
    drive(1, 1, 16, 0, 0); settle();
    chk(int'(footprint), 6, "R10 separate flags");

    drive(0, 0, 0, 0, 1); settle();
    chk(int'(footprint), 0, "R8 clear");

    drive(1, 1, 0, 0, 1); settle();
    chk(int'(footprint), 0, "R9 clear priority");

    drive(1, 1, 48, 2, 0);
    chk(int'(footprint), 0, "R7 not yet");
    settle();
    chk(int'(footprint), 1, "R7 one cycle later");

    for (int e = 0; e < 32; e++)
      for (int w = 0; w < 4; w++) drive(1, 1, e * 16, w, 0);
    settle();
    chk(int'(footprint), 128, "R6 full");
    drive(1, 1, 256, 1, 0); settle();
    chk(int'(footprint), 128, "R6 saturated");
    drive(0, 0, 0, 0, 1); settle();
    chk(int'(footprint), 0, "R8 clear from full");

    for (int k = 0; k < 3000; k++) begin
      automatic int s = ($urandom % 2 == 0) ? int'(($urandom % 32) * 16) : int'($urandom % 512);
      drive(bit'($urandom % 4 != 0), bit'($urandom % 3 != 0), s,
            int'($urandom % 4), bit'($urandom % 100 == 0));
    end
    settle();
    chk(int'(footprint), model_count(), "R6 after random");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule